// File: doc/BRIEF.md
# Control-Channel Payload Gold Scrambler

This block whitens a downlink control payload of up to 128 bits with a length-31 Gold pseudo-random sequence before the payload goes on to modulation. A single start pulse hands it the payload as four 32-bit words, the number of valid bits, a flag telling whether the payload belongs to a terminal-specific search space, the terminal's 16-bit RNTI, a configured 16-bit scrambling identity and the 10-bit physical cell identity. The block builds the generator seed from these, runs the two shift registers through their warm-up, and then XORs the sequence into the payload one bit per clock.

Sequence bits are collected into a 32-bit word. Each word is written to the output as soon as its last bit, or the last payload bit, has been produced. A one-cycle done pulse marks the result as complete. The result stays on the output until the next start is accepted.

Top module: `dci_gold_scrambler`

## Requirements
- R1: When `ueSpecific` is 1 the scrambling identity is `dmrsScrId`; when it is 0 the identity is `cellId`, zero-extended.
- R2: When `ueSpecific` is 1 the RNTI term is `rnti`; when it is 0 the RNTI term is zero, so `rnti` has no effect on the output.
- R3: The second register is seeded with (RNTI term × 65536 + identity) modulo 2^31. The first register is seeded with 1 in bit 0 and zeros elsewhere.
- R4: The registers follow x1(n+31) = x1(n+3) ^ x1(n) and x2(n+31) = x2(n+3) ^ x2(n+2) ^ x2(n+1) ^ x2(n).
- R5: Sequence bit c(n) = x1(n+1600) ^ x2(n+1600). Both registers are stepped 1600 times after seeding, at one step per clock, before c(0) is used.
- R6: Payload bit i is `payloadIn[i]`, which is bit i mod 32 of word i/32. For every i below the effective length, `dataOut[i]` = `payloadIn[i]` ^ c(i).
- R7: `dataOut[i]` is 0 for every i at or above the effective length. The effective length is `payloadLen`, clamped to 128. A length of 0 yields an all-zero output.
- R8: A start pulse that arrives while an operation is in progress is ignored. The running operation completes with its original inputs and produces exactly one done pulse.
- R9: `done` is high for exactly one cycle after the last payload bit has been scrambled. From that cycle on, `dataOut` holds the result unchanged until the next accepted start, even if the other inputs change.
- R10: After reset `done` is 0 and `dataOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only while idle |
| payloadIn | input | 128 | Payload; bit i is payload bit i |
| payloadLen | input | 8 | Number of valid payload bits (clamped to 128) |
| ueSpecific | input | 1 | 1 = terminal-specific search space |
| rnti | input | 16 | Terminal RNTI |
| dmrsScrId | input | 16 | Configured scrambling identity |
| cellId | input | 10 | Physical cell identity |
| dataOut | output | 128 | Scrambled payload; bits at or above the length are 0 |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
The assertions assume the inputs are sampled only in the cycle a start is accepted. They also assume the output may change only through a word commit while busy or a clear at accept, and that the held length never exceeds 128 once clamped. The stimulus holds start for one cycle and changes the payload and identity inputs freely while the block is busy or idle. It applies lengths of 0 and of more than 128 so that the clamp and the all-zero case are covered. A second start is issued in the middle of an operation to confirm that the block does not restart.

// File: rtl/gold_scr_pkg.sv
package gold_scr_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int LEN_W     = 8;
  localparam int LFSR_W    = 31;
  localparam int WARMUP    = 1600;
  localparam int RNTI_W    = 16;
  localparam int ID_W      = 16;
  localparam int CELL_W    = 10;

  // strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic seedLoad;
    logic outClear;
    logic genStep;
    logic bitCapture;
    logic wordCommit;
  } scrStrobe_t;
endpackage

// File: rtl/gold_seed_sel.sv
module gold_seed_sel #(
  parameter int RNTI_W = 16,
  parameter int ID_W   = 16,
  parameter int CELL_W = 10,
  parameter int LFSR_W = 31
) (
  input  logic              ueSpecific,
  input  logic [RNTI_W-1:0] rnti,
  input  logic [ID_W-1:0]   dmrsScrId,
  input  logic [CELL_W-1:0] cellId,
  output logic [LFSR_W-1:0] seed
);
  localparam int SUM_W = 32;
  logic [SUM_W-1:0] rntiTerm;
  logic [SUM_W-1:0] scrId;

  always_comb begin
    scrId    = ueSpecific ? SUM_W'(dmrsScrId) : SUM_W'(cellId);
    rntiTerm = ueSpecific ? SUM_W'(rnti) : '0;
    seed     = LFSR_W'((rntiTerm << 16) + scrId);
  end
endmodule

// File: rtl/gold_lfsr_pair.sv
module gold_lfsr_pair #(
  parameter int LFSR_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [LFSR_W-1:0] seedX2,
  output logic              seqBit
);
  logic [LFSR_W-1:0] x1Q;
  logic [LFSR_W-1:0] x2Q;
  logic              fb1;
  logic              fb2;

  always_comb begin
    fb1    = x1Q[3] ^ x1Q[0];
    fb2    = x2Q[3] ^ x2Q[2] ^ x2Q[1] ^ x2Q[0];
    seqBit = x1Q[0] ^ x2Q[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      x1Q <= '0;
      x2Q <= '0;
    end else if (load) begin
      x1Q <= LFSR_W'(1);
      x2Q <= seedX2;
    end else if (step) begin
      x1Q <= {fb1, x1Q[LFSR_W-1:1]};
      x2Q <= {fb2, x2Q[LFSR_W-1:1]};
    end
  end
endmodule

// File: rtl/scr_control.sv
module scr_control
  import gold_scr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEN_W     = 8,
  parameter int WARMUP    = 1600
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 start,
  input  logic [LEN_W-1:0]                     payloadLen,
  output scrStrobe_t                           str,
  output logic [$clog2(WORD_W*NUM_WORDS)-1:0]  bitIdx,
  output logic [LEN_W-1:0]                     lenHeld,
  output logic                                 busy,
  output logic                                 done
);
  localparam int PAY_W = WORD_W * NUM_WORDS;
  localparam int IDX_W = $clog2(PAY_W);
  localparam int SEL_W = $clog2(WORD_W);
  localparam int WC_W  = $clog2(WARMUP + 1);

  typedef enum logic [1:0] {S_IDLE, S_WARM, S_RUN} scrState_e;
  scrState_e        state;
  logic [WC_W-1:0]  warmCnt;
  logic [LEN_W-1:0] lenClamp;
  logic             accept;
  logic             lastBit;

  always_comb begin
    lenClamp = (payloadLen > LEN_W'(PAY_W)) ? LEN_W'(PAY_W) : payloadLen;
    accept   = (state == S_IDLE) && start;
    lastBit  = (state == S_RUN) && (LEN_W'(bitIdx) == lenHeld - LEN_W'(1));
    busy     = (state != S_IDLE);
    str            = '0;
    str.seedLoad   = accept;
    str.outClear   = accept;
    str.genStep    = (state != S_IDLE);
    str.bitCapture = (state == S_RUN);
    str.wordCommit = (state == S_RUN) && ((&bitIdx[SEL_W-1:0]) || lastBit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      warmCnt <= '0;
      bitIdx  <= '0;
      lenHeld <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            lenHeld <= lenClamp;
            warmCnt <= '0;
            bitIdx  <= '0;
            state   <= S_WARM;
          end
        end
        S_WARM: begin
          warmCnt <= warmCnt + WC_W'(1);
          if (warmCnt == WC_W'(WARMUP - 1)) begin
            if (lenHeld == '0) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              state <= S_RUN;
            end
          end
        end
        S_RUN: begin
          bitIdx <= bitIdx + IDX_W'(1);
          if (lastBit) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import gold_scr_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  parameter int LEN_W     = 8,
  parameter int LFSR_W    = 31,
  parameter int RNTI_W    = 16,
  parameter int ID_W      = 16,
  parameter int CELL_W    = 10
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  scrStrobe_t                           str,
  input  logic [$clog2(WORD_W*NUM_WORDS)-1:0]  bitIdx,
  input  logic [LEN_W-1:0]                     lenHeld,
  input  logic [WORD_W*NUM_WORDS-1:0]          payloadIn,
  input  logic                                 ueSpecific,
  input  logic [RNTI_W-1:0]                    rnti,
  input  logic [ID_W-1:0]                      dmrsScrId,
  input  logic [CELL_W-1:0]                    cellId,
  output logic [WORD_W*NUM_WORDS-1:0]          dataOut
);
  localparam int PAY_W  = WORD_W * NUM_WORDS;
  localparam int SEL_W  = $clog2(WORD_W);
  localparam int WSEL_W = $clog2(NUM_WORDS);

  logic [LFSR_W-1:0] seed;
  logic              seqBit;
  logic [PAY_W-1:0]  payloadQ;
  logic [WORD_W-1:0] seqWordQ;
  logic [WORD_W-1:0] seqNext;
  logic [WORD_W-1:0] tailMask;
  logic [SEL_W-1:0]  bitSel;
  logic [WSEL_W-1:0] wordSel;

  gold_seed_sel #(
    .RNTI_W(RNTI_W), .ID_W(ID_W), .CELL_W(CELL_W), .LFSR_W(LFSR_W)
  ) seed_i (
    .ueSpecific(ueSpecific),
    .rnti      (rnti),
    .dmrsScrId (dmrsScrId),
    .cellId    (cellId),
    .seed      (seed)
  );

  gold_lfsr_pair #(.LFSR_W(LFSR_W)) gen_i (
    .clk   (clk),
    .rstN  (rstN),
    .load  (str.seedLoad),
    .step  (str.genStep),
    .seedX2(seed),
    .seqBit(seqBit)
  );

  always_comb begin
    bitSel  = bitIdx[SEL_W-1:0];
    wordSel = bitIdx[SEL_W +: WSEL_W];
    seqNext = seqWordQ;
    if (str.bitCapture) seqNext[bitSel] = seqBit;
    for (int j = 0; j < WORD_W; j++) begin
      tailMask[j] = (LEN_W'({wordSel, SEL_W'(j)}) < lenHeld);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payloadQ <= '0;
      seqWordQ <= '0;
    end else if (str.seedLoad) begin
      payloadQ <= payloadIn;
      seqWordQ <= '0;
    end else begin
      seqWordQ <= seqNext;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ <= '0;
      end else if (str.outClear) begin
        wordQ <= '0;
      end else if (str.wordCommit && (wordSel == WSEL_W'(w))) begin
        wordQ <= (payloadQ[w*WORD_W +: WORD_W] ^ seqNext) & tailMask;
      end
    end
    assign dataOut[w*WORD_W +: WORD_W] = wordQ;
  end
endmodule

// File: rtl/dci_gold_scrambler.sv
module dci_gold_scrambler
  import gold_scr_pkg::*;
#(
  parameter int WORD_W    = gold_scr_pkg::WORD_W,
  parameter int NUM_WORDS = gold_scr_pkg::NUM_WORDS,
  parameter int LEN_W     = gold_scr_pkg::LEN_W,
  parameter int LFSR_W    = gold_scr_pkg::LFSR_W,
  parameter int WARMUP    = gold_scr_pkg::WARMUP,
  parameter int RNTI_W    = gold_scr_pkg::RNTI_W,
  parameter int ID_W      = gold_scr_pkg::ID_W,
  parameter int CELL_W    = gold_scr_pkg::CELL_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [WORD_W*NUM_WORDS-1:0] payloadIn,
  input  logic [LEN_W-1:0]            payloadLen,
  input  logic                        ueSpecific,
  input  logic [RNTI_W-1:0]           rnti,
  input  logic [ID_W-1:0]             dmrsScrId,
  input  logic [CELL_W-1:0]           cellId,
  output logic [WORD_W*NUM_WORDS-1:0] dataOut,
  output logic                        done
);
  localparam int PAY_W = WORD_W * NUM_WORDS;
  localparam int IDX_W = $clog2(PAY_W);

  scrStrobe_t       ctrlStr;
  logic [IDX_W-1:0] bitIdx;
  logic [LEN_W-1:0] lenHeld;
  logic             busy;

  scr_control #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .LEN_W(LEN_W), .WARMUP(WARMUP)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .payloadLen(payloadLen),
    .str       (ctrlStr),
    .bitIdx    (bitIdx),
    .lenHeld   (lenHeld),
    .busy      (busy),
    .done      (done)
  );

  scr_datapath #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .LEN_W(LEN_W), .LFSR_W(LFSR_W),
    .RNTI_W(RNTI_W), .ID_W(ID_W), .CELL_W(CELL_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .str       (ctrlStr),
    .bitIdx    (bitIdx),
    .lenHeld   (lenHeld),
    .payloadIn (payloadIn),
    .ueSpecific(ueSpecific),
    .rnti      (rnti),
    .dmrsScrId (dmrsScrId),
    .cellId    (cellId),
    .dataOut   (dataOut)
  );
endmodule

// File: rtl/dci_gold_scrambler_chk.sv
module dci_gold_scrambler_chk #(
  parameter int PAY_W = 128,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             commit,
  input logic [LEN_W-1:0] lenHeld,
  input logic [PAY_W-1:0] dataOut
);
  logic [PAY_W-1:0] lenMask;
  always_comb begin
    for (int i = 0; i < PAY_W; i++) lenMask[i] = (i < int'(lenHeld));
  end

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: result held while idle without a start
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(dataOut));

  // R8: during an operation the output moves only by word commits
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !commit) |=> $stable(dataOut));

  // R7: bits at or above the length are zero when done
  p_tail_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((dataOut & ~lenMask) == '0));

  // R6: commits only happen inside an operation
  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> busy);
endmodule

bind dci_gold_scrambler dci_gold_scrambler_chk #(
  .PAY_W(WORD_W * NUM_WORDS), .LEN_W(LEN_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .commit (ctrlStr.wordCommit),
  .lenHeld(lenHeld),
  .dataOut(dataOut)
);

// File: tb/dci_gold_scrambler_tb_top.sv
module dci_gold_scrambler_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] payloadIn = '0;
  logic [7:0]   payloadLen = '0;
  logic         ueSpecific = 1'b0;
  logic [15:0]  rnti = '0;
  logic [15:0]  dmrsScrId = '0;
  logic [9:0]   cellId = '0;
  logic [127:0] dataOut;
  logic         done;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  dci_gold_scrambler dut_i (
    .clk(clk), .rstN(rstN), .start(start), .payloadIn(payloadIn),
    .payloadLen(payloadLen), .ueSpecific(ueSpecific), .rnti(rnti),
    .dmrsScrId(dmrsScrId), .cellId(cellId), .dataOut(dataOut), .done(done)
  );

  function automatic logic [127:0] refOut(input logic [127:0] p, input int len,
      input logic ue, input logic [15:0] rn, input logic [15:0] dm, input logic [9:0] cid);
    logic [31:0]  idv, rt, s;
    logic [30:0]  x1, x2;
    logic         c;
    logic [127:0] r;
    int           effLen;
    effLen = (len > 128) ? 128 : len;
    idv = ue ? {16'd0, dm} : {22'd0, cid};     // R1
    rt  = ue ? {16'd0, rn} : 32'd0;            // R2
    s   = (rt << 16) + idv;                    // R3
    x1  = 31'd1;
    x2  = s[30:0];
    r   = '0;
    for (int n = 0; n < 1600 + 128; n++) begin // R4, R5
      if (n >= 1600) begin
        c = x1[0] ^ x2[0];
        if (n - 1600 < effLen) r[n-1600] = p[n-1600] ^ c; // R6, R7
      end
      x1 = {x1[3] ^ x1[0], x1[30:1]};
      x2 = {x2[3] ^ x2[2] ^ x2[1] ^ x2[0], x2[30:1]};
    end
    return r;
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
      input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitDone(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 4000 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic runOp(input logic [127:0] p, input int len, input logic ue,
      input logic [15:0] rn, input logic [15:0] dm, input logic [9:0] cid, input string req);
    logic [127:0] exp;
    logic         seen;
    exp = refOut(p, len, ue, rn, dm, cid);
    @(negedge clk);
    payloadIn = p; payloadLen = 8'(len); ueSpecific = ue;
    rnti = rn; dmrsScrId = dm; cellId = cid; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    payloadIn = ~p; rnti = ~rn; // inputs after accept must not matter
    waitDone(seen);
    check(seen, {req, " R9 done seen"}, 128'(seen), 128'd1);
    check(dataOut == exp, req, dataOut, exp);
    @(negedge clk);
    check(!done, "R9 done one cycle", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [127:0] p;
    logic [127:0] held;
    logic [127:0] expA;
    logic         seen;
    int           extra;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R10 reset done", 128'(done), 128'd0);
    check(dataOut == '0, "R10 reset data", dataOut, '0);
    rstN = 1'b1;

    p = {$urandom, $urandom, $urandom, $urandom};
    // directed lengths, both search-space types
    runOp(p, 1,   1'b1, 16'hBEEF, 16'h1234, 10'd501, "R6 ue len1");
    runOp(p, 31,  1'b1, 16'hFFFF, 16'hFFFF, 10'd7,   "R3 ue len31 seed wrap");
    runOp(p, 32,  1'b1, 16'h0042, 16'h0010, 10'd0,   "R1 ue len32");
    runOp(p, 33,  1'b1, 16'h8001, 16'h0333, 10'd100, "R6 ue len33");
    runOp(p, 128, 1'b1, 16'h4321, 16'h0BAD, 10'd999, "R5 ue len128");
    runOp(p, 1,   1'b0, 16'hBEEF, 16'h1234, 10'd501, "R2 common len1");
    runOp(p, 31,  1'b0, 16'h1111, 16'h2222, 10'd1007,"R1 common len31");
    runOp(p, 32,  1'b0, 16'h0000, 16'h0000, 10'd0,   "R4 common len32 id0");
    runOp(p, 33,  1'b0, 16'hAAAA, 16'h5555, 10'd1023,"R2 common len33");
    runOp(p, 128, 1'b0, 16'h7777, 16'h0001, 10'd256, "R4 common len128");
    runOp(p, 0,   1'b1, 16'h0001, 16'h0002, 10'd3,   "R7 len0");
    runOp(p, 200, 1'b1, 16'h0101, 16'h0202, 10'd4,   "R7 len clamp");

    // R8: second start while busy is ignored
    p = {$urandom, $urandom, $urandom, $urandom};
    expA = refOut(p, 77, 1'b1, 16'h2468, 16'h1357, 10'd12);
    @(negedge clk);
    payloadIn = p; payloadLen = 8'd77; ueSpecific = 1'b1;
    rnti = 16'h2468; dmrsScrId = 16'h1357; cellId = 10'd12; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    payloadIn = ~p; payloadLen = 8'd5; ueSpecific = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check(seen, "R8 done seen", 128'(seen), 128'd1);
    check(dataOut == expA, "R8 busy start ignored", dataOut, expA);
    extra = 0;
    for (int k = 0; k < 1800; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R8 single done", 128'(extra), 128'd0);

    // R9: result held while idle with changing inputs
    held = dataOut;
    payloadIn = {$urandom, $urandom, $urandom, $urandom};
    payloadLen = 8'd3; rnti = 16'h9999; cellId = 10'd1;
    repeat (10) @(negedge clk);
    check(dataOut == held, "R9 idle hold", dataOut, held);

    // constrained random operations
    for (int t = 0; t < 16; t++) begin
      runOp({$urandom, $urandom, $urandom, $urandom}, int'($urandom_range(1, 128)),
            1'($urandom), 16'($urandom), 16'($urandom), 10'($urandom), "R6 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule